// File: doc/BRIEF.md
# Throttled Prefetch Buffer

A small fully-associative store that sits next to the first-level data cache. A prefetch engine pushes whole blocks into it, each tagged by its block-aligned address, and the CPU looks up its own addresses against every entry in the same cycle. A lookup that hits returns the block and frees its entry.

Each entry carries an occupancy flag, the inverse of a free bit. Filling an entry marks it used, and consuming it marks it free again. When every entry is in use, a registered suspend output tells the engine to stop. That output drops once the CPU frees an entry. This gives credit-style flow control. The engine cannot run further ahead of the CPU than the buffer holds, and each consumption lets it resume.

A write to a block address that is already held overwrites that entry and takes no new entry. A new block goes to the lowest-numbered free entry. When a lookup and a write arrive in the same cycle, the lookup is applied first.

Top module: `pfb_top`

## Requirements
- R1: After reset every entry is free, `suspend_o` is 0 and no lookup hits.
- R2: A write of a block into a free entry makes a later lookup of any byte address within that block (the tag is `addr[ADDR_W-1:log2(BLK_BYTES)]`) hit and return the written data in the same cycle as the lookup.
- R3: A lookup that hits frees its entry, so an immediately repeated lookup of the same block misses.
- R4: A lookup that misses returns `rd_hit_o`=0 with `rd_data_o` all zeros and changes no entry.
- R5: A write to a block already held replaces that entry's data and takes no second entry, including when the buffer is full.
- R6: `suspend_o` rises at the clock edge that fills the last free entry and is 1 exactly while every entry is in use.
- R7: A consuming lookup on a full buffer clears `suspend_o` at that same edge, unless a write in the same cycle takes the freed entry.
- R8: A write of a new block while every entry is in use is dropped, and a later lookup of that block misses.
- R9: When a lookup and a write share a cycle, the lookup sees the contents from before the write. An entry freed by that lookup is available to that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Engine pushes a block this cycle |
| wr_addr_i | input | ADDR_W | Address of the pushed block |
| wr_data_i | input | 8*BLK_BYTES | Pushed block contents |
| rd_valid_i | input | 1 | CPU lookup this cycle |
| rd_addr_i | input | ADDR_W | CPU lookup address |
| rd_hit_o | output | 1 | Lookup matched an occupied entry |
| rd_data_o | output | 8*BLK_BYTES | Matched block, zero on a miss |
| suspend_o | output | 1 | Engine must stall, all entries in use |

## Verification
The bench builds the block with ENTRIES=4, ADDR_W=12 and BLK_BYTES=4. With only four entries, every occupancy level from empty to full, and the full-buffer drop, overwrite and consume-while-writing cases, can be reached in a few cycles. Sweeps run over every tag in a three-bit window with varied in-block offsets. A long pseudo-random phase then drives reads and writes against an occupancy model computed in the bench. That narrow tag window makes hits, overwrites and same-cycle collisions frequent.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  function automatic int unsigned off_bits(input int unsigned bytes);
    return (bytes <= 1) ? 1 : $clog2(bytes);
  endfunction
endpackage

// File: rtl/pfb_slot.sv
module pfb_slot #(
  parameter int unsigned TAG_W  = 27,
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rel_i,
  input  logic              wr_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              occ_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  logic              occ_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_i) begin
        occ_q  <= 1'b1;
        tag_q  <= tag_i;
        data_q <= data_i;
      end else if (rel_i) begin
        occ_q  <= 1'b0;
      end
    end
  end

  assign occ_o  = occ_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;

  // R2: a write leaves the entry occupied with the written tag
  a_r2_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (occ_q && tag_q == $past(tag_i)));
  // R3: a release without a write empties the entry
  a_r3_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !wr_i) |=> !occ_q);
endmodule

// File: rtl/pfb_lookup.sv
module pfb_lookup #(
  parameter int unsigned N     = 32,
  parameter int unsigned TAG_W = 27
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              occ_i,
  input  logic [N-1:0][TAG_W-1:0]   tags_i,
  input  logic                      rd_valid_i,
  input  logic [TAG_W-1:0]          rd_tag_i,
  input  logic                      wr_valid_i,
  input  logic [TAG_W-1:0]          wr_tag_i,
  output logic [N-1:0]              rd_hit_o,
  output logic [N-1:0]              wr_sel_o
);
  logic [N-1:0] left_occ;
  logic [N-1:0] wr_match;
  logic [N-1:0] free_vec;
  logic [N-1:0] low_free;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign rd_hit_o[i] = rd_valid_i & occ_i[i] & (tags_i[i] == rd_tag_i);
    assign wr_match[i] = left_occ[i] & (tags_i[i] == wr_tag_i);
  end

  // lookup is applied first: its hit is already treated as freed
  assign left_occ = occ_i & ~rd_hit_o;
  assign free_vec = ~left_occ;
  assign low_free = free_vec & (~free_vec + 1'b1);

  always_comb begin
    if (!wr_valid_i)   wr_sel_o = '0;
    else if (|wr_match) wr_sel_o = wr_match;
    else               wr_sel_o = low_free;
  end

  // R5: a tag is never held twice, so at most one entry matches
  a_r5_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_match) && $onehot0(rd_hit_o));
  // R8: at most one entry is written per cycle
  a_r8_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/pfb_top.sv
module pfb_top #(
  parameter int unsigned ENTRIES   = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_valid_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [8*BLK_BYTES-1:0]   wr_data_i,
  input  logic                     rd_valid_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic                     rd_hit_o,
  output logic [8*BLK_BYTES-1:0]   rd_data_o,
  output logic                     suspend_o
);
  localparam int unsigned OFF_W  = pfb_pkg::off_bits(BLK_BYTES);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W;
  localparam int unsigned DATA_W = 8 * BLK_BYTES;

  logic [ENTRIES-1:0]              occ_vec;
  logic [ENTRIES-1:0][TAG_W-1:0]   tag_vec;
  logic [ENTRIES-1:0][DATA_W-1:0]  data_vec;
  logic [ENTRIES-1:0]              hit_vec;
  logic [ENTRIES-1:0]              wsel_vec;
  logic [ENTRIES-1:0]              occ_nxt;
  logic [TAG_W-1:0]                rd_tag, wr_tag;
  logic                            suspend_q;

  assign rd_tag = rd_addr_i[ADDR_W-1:OFF_W];
  assign wr_tag = wr_addr_i[ADDR_W-1:OFF_W];

  pfb_lookup #(.N(ENTRIES), .TAG_W(TAG_W)) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .occ_i      (occ_vec),
    .tags_i     (tag_vec),
    .rd_valid_i (rd_valid_i),
    .rd_tag_i   (rd_tag),
    .wr_valid_i (wr_valid_i),
    .wr_tag_i   (wr_tag),
    .rd_hit_o   (hit_vec),
    .wr_sel_o   (wsel_vec)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    pfb_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rel_i  (hit_vec[i]),
      .wr_i   (wsel_vec[i]),
      .tag_i  (wr_tag),
      .data_i (wr_data_i),
      .occ_o  (occ_vec[i]),
      .tag_o  (tag_vec[i]),
      .data_o (data_vec[i])
    );
    assign occ_nxt[i] = wsel_vec[i] | (occ_vec[i] & ~hit_vec[i]);
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) rd_data_o = rd_data_o | data_vec[i];
  end
  assign rd_hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) suspend_q <= 1'b0;
    else         suspend_q <= &occ_nxt;
  end
  assign suspend_o = suspend_q;

  // R6/R7: throttle tracks full occupancy
  a_r6_suspend_tracks_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o == (&occ_vec));
  // R4: a miss returns zero data
  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_o |-> (rd_data_o == '0));
endmodule

// File: tb/sim_pfb_top.sv
module sim_pfb_top;
  localparam int N = 4, AW = 12, BB = 4, DW = 8 * BB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wv = 0, rv = 0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic hit, susp;
  logic [DW-1:0] rdat;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pfb_top #(.ENTRIES(N), .ADDR_W(AW), .BLK_BYTES(BB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_valid_i(rv), .rd_addr_i(ra), .rd_hit_o(hit), .rd_data_o(rdat), .suspend_o(susp));

  // model of held blocks
  logic          mv [N];
  logic [AW-3:0] mt [N];
  logic [DW-1:0] md [N];

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic full_m();
    for (int i = 0; i < N; i++) if (!mv[i]) return 1'b0;
    return 1'b1;
  endfunction

  // one cycle: drive at negedge, check lookup, model, edge, check suspend
  task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic r, input logic [AW-1:0] b, input string tag);
    logic eh; logic [DW-1:0] ed; logic done;
    @(negedge clk);
    wv = w; wa = a; wd = d; rv = r; ra = b;
    #1;
    eh = 1'b0; ed = '0;
    if (r) for (int i = 0; i < N; i++)
      if (mv[i] && mt[i] == b[AW-1:2]) begin eh = 1'b1; ed = md[i]; mv[i] = 1'b0; end
    chk({tag, " R2/R3 hit"}, DW'(hit), DW'(eh));
    chk({tag, " R4 data"}, rdat, ed);
    if (w) begin
      done = 1'b0;
      for (int i = 0; i < N; i++)
        if (!done && mv[i] && mt[i] == a[AW-1:2]) begin md[i] = d; done = 1'b1; end
      for (int i = 0; i < N; i++)
        if (!done && !mv[i]) begin mv[i] = 1'b1; mt[i] = a[AW-1:2]; md[i] = d; done = 1'b1; end
    end
    @(posedge clk); #1;
    wv = 0; rv = 0;
    chk({tag, " R6/R7 suspend"}, DW'(susp), DW'(full_m()));
  endtask

  function automatic logic [AW-1:0] adr(input int t, input int off);
    return AW'((t << 2) | (off & 3));
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
    #20;
    chk("R1 suspend at reset", DW'(susp), '0);
    chk("R1 hit at reset", DW'(hit), '0);
    rst_n = 1'b1;
    step(0, 0, 0, 1, adr(0, 0), "R1 empty lookup");
    // R2/R3: every tag in window, read at varied offsets, second read misses
    for (int t = 0; t < 8; t++) begin
      step(1, adr(t, t), DW'(32'hA500 + t), 0, 0, "R2 fill");
      step(0, 0, 0, 1, adr(t, t + 1), "R2 readback");
      step(0, 0, 0, 1, adr(t, t + 2), "R3 reread miss");
    end
    // R6: suspend only after the last entry fills
    for (int t = 0; t < N; t++) step(1, adr(t, 0), DW'(32'hB0 + t), 0, 0, "R6 fill");
    chk("R6 full", DW'(susp), 1);
    // R8: new block dropped while full
    step(1, adr(7, 0), DW'(32'hDEAD), 0, 0, "R8 drop");
    // R5: overwrite in place while full
    step(1, adr(1, 3), DW'(32'hC1), 0, 0, "R5 overwrite");
    step(0, 0, 0, 1, adr(1, 0), "R5 new data");
    // R7: that consumption freed one entry
    chk("R7 resume", DW'(susp), 0);
    step(0, 0, 0, 1, adr(7, 0), "R8 dropped miss");
    step(1, adr(5, 0), DW'(32'hE5), 0, 0, "R6 refill");
    // R9: consume and write new block same cycle while full
    step(1, adr(6, 0), DW'(32'hF6), 1, adr(0, 2), "R9 swap");
    chk("R9 still full", DW'(susp), 1);
    // R9: read and overwrite same block same cycle
    step(1, adr(6, 1), DW'(32'h66), 1, adr(6, 0), "R9 read-old");
    step(0, 0, 0, 1, adr(6, 0), "R9 write-after");
    // R4 miss on empty-ish tags, then drain
    for (int t = 0; t < 8; t++) step(0, 0, 0, 1, adr(t, 0), "R4 drain");
    // random phase
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], adr(lfsr[3:1], lfsr[5:4]), DW'({lfsr, lfsr[7:0], 8'(k)}),
           lfsr[6] | lfsr[7], adr(lfsr[10:8], lfsr[12:11]), "R9 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule